// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End with Busy Silence

This block is the bus-facing half of a small register device reached over a two-wire serial bus. It samples the clock and data lines with the system clock, finds START and STOP conditions, and assembles bytes most significant bit first. It acknowledges by pulling the data line low during the ninth clock, and it shifts read data back out. The first byte of every transaction selects the device. Its upper nibble is a fixed type code, 0101. Its lower nibble must equal four strap pins. The byte carries no read/write bit.

The second byte goes to a command engine as an instruction. The engine answers with two decisions: whether to acknowledge, and whether the rest of the transaction is a read. The front end then passes later write bytes to the engine, or sends the engine's read byte for as long as the host keeps acknowledging. While the engine signals that a non-volatile write is in progress, the front end does not answer its address. A host can therefore poll for the acknowledge to learn when the write has finished. The engine uses the STOP pulse to commit a pending write.

Top module: `twoWireSlave`

## Requirements
- R1: SDA falling while SCL is high (both as seen after synchronization) is a START. It pulses `startSeen`, clears the bit count and begins a new address byte, even in the middle of a byte.
- R2: SDA rising while SCL is high is a STOP. It returns the block to idle with SDA released. It pulses `stopSel` for one cycle only if this device acknowledged its address since the last START.
- R3: The address byte is received MSB first. When bits [7:4] equal 0101, bits [3:0] equal `strapAddr` and `nvBusy` is low, the block pulls SDA low for the whole ninth SCL clock.
- R4: After any other address byte, the block does not pull SDA and raises no `instrValid`, `dataValid`, `rdNext` or `stopSel` until the next START.
- R5: If `nvBusy` is high when the last address bit is sampled, a matching address gets no acknowledge. SDA stays high until the next START.
- R6: The byte after an acknowledged address appears on `rxByte` with a one-cycle `instrValid`. It is acknowledged when `engAck` is high. `engRead` high then makes the following bytes reads, and low makes them writes. No two of the output pulses are ever high in the same cycle.
- R7: In write mode, each byte appears on `rxByte` with a one-cycle `dataValid` and is acknowledged when `engAck` is high. When `engAck` is low, the byte and all later bytes get no acknowledge.
- R8: In read mode, the block sends `rdByte` MSB first and releases SDA in the ninth clock. A host acknowledge pulses `rdNext` and a fresh `rdByte` follows. A host non-acknowledge leaves SDA released until STOP or START.
- R9: `sdaPullLow` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | High pulls the open-drain data line low |
| strapAddr | input | 4 | Pin-strapped low nibble of the device address |
| nvBusy | input | 1 | Engine non-volatile write in progress |
| engAck | input | 1 | Engine accepts the current instruction or data byte |
| engRead | input | 1 | Engine declares the instruction a read |
| rdByte | input | 8 | Byte to send on the next read byte |
| rxByte | output | 8 | Last received instruction or data byte |
| instrValid | output | 1 | One-cycle pulse: instruction byte on rxByte |
| dataValid | output | 1 | One-cycle pulse: write data byte on rxByte |
| rdNext | output | 1 | One-cycle pulse: host acknowledged a read byte |
| startSeen | output | 1 | One-cycle pulse on START |
| stopSel | output | 1 | One-cycle pulse on STOP ending a selected transaction |

## Verification
The bench restarts in the middle of a byte. A design that kept its bit count would shift the new address out of frame and miss the acknowledge. It polls with `nvBusy` high and then low. A design that sampled the busy flag at the wrong time, or ignored it, would acknowledge too early or never. It ends a read with a host non-acknowledge and then clocks another byte. A slave still driving would corrupt the all-ones pattern the bench expects. It also sends foreign addresses and checks that no STOP pulse, no strobe and no SDA edge appears while SCL is high, since an edge there would turn into a false START or STOP on the bus.

// File: rtl/twsPkg.sv
package twsPkg;
  typedef enum logic [1:0] {DRV_HOLD, DRV_REL, DRV_ACK} drvSel_t;

  typedef struct packed {
    logic    clrBits;
    logic    shiftIn;
    logic    loadTx;
    logic    shiftTx;
    drvSel_t drv;
  } dpCtl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_WAIT_STOP
  } busState_t;
endpackage

// File: rtl/twsLineSync.sv
module twsLineSync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rawIn,      // [1] = SCL, [0] = SDA
  output logic       sclS,
  output logic       sdaS,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startCond,
  output logic       stopCond
);
  logic [1:0] syncd;
  logic       sclP, sdaP;

  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign syncd[g] = chain[STAGES-1];
  end

  assign sclS = syncd[1];
  assign sdaS = syncd[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startCond = sclS & sclP & sdaP & ~sdaS;
  assign stopCond  = sclS & sclP & ~sdaP & sdaS;
endmodule

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              STRAP_W  = 4,
  parameter logic [DATA_W-STRAP_W-1:0] DEV_TYPE = 4'b0101,
  localparam int             CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic               sdaS,
  input  logic [DATA_W-1:0]  rdByte,
  input  logic [STRAP_W-1:0] strapAddr,
  output logic               lastBit,
  output logic               byteFull,
  output logic               addrHit,
  output logic [DATA_W-1:0]  rxByte,
  output logic               sdaLow
);
  logic [DATA_W-2:0] shiftReg;
  logic [DATA_W-2:0] txReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] rxNext;

  assign rxNext   = {shiftReg, sdaS};
  assign lastBit  = (bitCnt == CNT_W'(DATA_W - 1));
  assign byteFull = (bitCnt == CNT_W'(DATA_W));
  assign addrHit  = (rxNext[DATA_W-1:STRAP_W] == DEV_TYPE) &&
                    (rxNext[STRAP_W-1:0] == strapAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      rxByte   <= '0;
    end else if (ctl.clrBits) begin
      bitCnt <= '0;
    end else if (ctl.shiftIn) begin
      shiftReg <= rxNext[DATA_W-2:0];
      bitCnt   <= bitCnt + 1'b1;
      if (lastBit) rxByte <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '0;
      sdaLow <= 1'b0;
    end else if (ctl.loadTx) begin
      txReg  <= rdByte[DATA_W-2:0];
      sdaLow <= ~rdByte[DATA_W-1];
    end else if (ctl.shiftTx) begin
      txReg  <= {txReg[DATA_W-3:0], 1'b0};
      sdaLow <= ~txReg[DATA_W-2];
    end else begin
      case (ctl.drv)
        DRV_REL: sdaLow <= 1'b0;
        DRV_ACK: sdaLow <= 1'b1;
        default: sdaLow <= sdaLow;
      endcase
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(DATA_W)); // R1
endmodule

// File: rtl/twsControl.sv
module twsControl
  import twsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startCond,
  input  logic      stopCond,
  input  logic      sdaS,
  input  logic      lastBit,
  input  logic      byteFull,
  input  logic      addrHit,
  input  logic      nvBusy,
  input  logic      engAck,
  input  logic      engRead,
  output dpCtl_t    ctl,
  output busState_t state,
  output logic      instrValid,
  output logic      dataValid,
  output logic      rdNext,
  output logic      startSeen,
  output logic      stopSel
);
  busState_t stateN;
  logic ackPend, ackPendN, mAck, mAckN, readMode, readModeN, selected, selectedN;
  logic instrP, dataP, rdP, startP, stopP;

  always_comb begin
    ctl       = '{clrBits: 1'b0, shiftIn: 1'b0, loadTx: 1'b0, shiftTx: 1'b0, drv: DRV_HOLD};
    stateN    = state;
    ackPendN  = ackPend;
    mAckN     = mAck;
    readModeN = readMode;
    selectedN = selected;
    instrP = 1'b0; dataP = 1'b0; rdP = 1'b0; startP = 1'b0; stopP = 1'b0;
    if (startCond) begin
      stateN      = ST_ADDR;
      ctl.clrBits = 1'b1;
      ctl.drv     = DRV_REL;
      selectedN   = 1'b0;
      startP      = 1'b1;
    end else if (stopCond) begin
      stateN    = ST_IDLE;
      ctl.drv   = DRV_REL;
      stopP     = selected;
      selectedN = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            if (lastBit) ackPendN = addrHit && !nvBusy;
          end else if (sclFall && byteFull) begin
            if (ackPend) begin
              stateN    = ST_ADDR_ACK;
              ctl.drv   = DRV_ACK;
              selectedN = 1'b1;
            end else begin
              stateN = ST_WAIT_STOP;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          stateN      = ST_INSTR;
          ctl.clrBits = 1'b1;
          ctl.drv     = DRV_REL;
        end
        ST_INSTR: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            instrP      = lastBit;
          end else if (sclFall && byteFull) begin
            if (engAck) begin
              stateN    = ST_INSTR_ACK;
              ctl.drv   = DRV_ACK;
              readModeN = engRead;
            end else begin
              stateN = ST_WAIT_STOP;
            end
          end
        end
        ST_INSTR_ACK: if (sclFall) begin
          ctl.clrBits = 1'b1;
          if (readMode) begin
            stateN     = ST_RDATA;
            ctl.loadTx = 1'b1;
          end else begin
            stateN  = ST_WDATA;
            ctl.drv = DRV_REL;
          end
        end
        ST_WDATA: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            dataP       = lastBit;
          end else if (sclFall && byteFull) begin
            if (engAck) begin
              stateN  = ST_WDATA_ACK;
              ctl.drv = DRV_ACK;
            end else begin
              stateN = ST_WAIT_STOP;
            end
          end
        end
        ST_WDATA_ACK: if (sclFall) begin
          stateN      = ST_WDATA;
          ctl.clrBits = 1'b1;
          ctl.drv     = DRV_REL;
        end
        ST_RDATA: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
          end else if (sclFall) begin
            if (byteFull) begin
              stateN  = ST_RDATA_ACK;
              ctl.drv = DRV_REL;
            end else begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (sclRise) begin
            mAckN = ~sdaS;
            rdP   = ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              stateN      = ST_RDATA;
              ctl.clrBits = 1'b1;
              ctl.loadTx  = 1'b1;
            end else begin
              stateN = ST_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ackPend    <= 1'b0;
      mAck       <= 1'b0;
      readMode   <= 1'b0;
      selected   <= 1'b0;
      instrValid <= 1'b0;
      dataValid  <= 1'b0;
      rdNext     <= 1'b0;
      startSeen  <= 1'b0;
      stopSel    <= 1'b0;
    end else begin
      state      <= stateN;
      ackPend    <= ackPendN;
      mAck       <= mAckN;
      readMode   <= readModeN;
      selected   <= selectedN;
      instrValid <= instrP;
      dataValid  <= dataP;
      rdNext     <= rdP;
      startSeen  <= startP;
      stopSel    <= stopP;
    end
  end

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    startCond |=> (state == ST_ADDR)); // R1
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopCond |=> (state == ST_IDLE)); // R2
  AST_STOPSEL_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopSel |-> (state == ST_IDLE)); // R2
endmodule

// File: rtl/twoWireSlave.sv
module twoWireSlave
  import twsPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int STRAP_W     = 4,
  parameter logic [DATA_W-STRAP_W-1:0] DEV_TYPE = 4'b0101
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaPullLow,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic               nvBusy,
  input  logic               engAck,
  input  logic               engRead,
  input  logic [DATA_W-1:0]  rdByte,
  output logic [DATA_W-1:0]  rxByte,
  output logic               instrValid,
  output logic               dataValid,
  output logic               rdNext,
  output logic               startSeen,
  output logic               stopSel
);
  logic      sclS, sdaS, sclRise, sclFall, startCond, stopCond;
  logic      lastBit, byteFull, addrHit;
  dpCtl_t    ctl;
  busState_t state;

  twsLineSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn({sclIn, sdaIn}),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond)
  );

  twsControl u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .sdaS(sdaS),
    .lastBit(lastBit), .byteFull(byteFull), .addrHit(addrHit),
    .nvBusy(nvBusy), .engAck(engAck), .engRead(engRead),
    .ctl(ctl), .state(state), .instrValid(instrValid), .dataValid(dataValid),
    .rdNext(rdNext), .startSeen(startSeen), .stopSel(stopSel)
  );

  twsDatapath #(.DATA_W(DATA_W), .STRAP_W(STRAP_W), .DEV_TYPE(DEV_TYPE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaS(sdaS), .rdByte(rdByte),
    .strapAddr(strapAddr), .lastBit(lastBit), .byteFull(byteFull),
    .addrHit(addrHit), .rxByte(rxByte), .sdaLow(sdaPullLow)
  );

  AST_SILENT_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_ADDR || state == ST_WAIT_STOP) |-> !sdaPullLow); // R4 R5
  AST_READ_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDATA_ACK) |-> !sdaPullLow); // R8
  AST_PULL_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclS); // R9
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({instrValid, dataValid, rdNext, startSeen, stopSel})); // R6
endmodule

// File: tb/twoWireSlave_tb.sv
module twoWireSlave_tb;
  localparam logic [3:0] STRAP = 4'hA;

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic nvBusy = 1'b0, engAck = 1'b1, engRead = 1'b0;
  logic [7:0] rdBase = 8'h00;
  logic [7:0] rdByte, rxByte;
  logic sdaPullLow, instrValid, dataValid, rdNext, startSeen, stopSel;
  logic sdaBus;

  int checks = 0, fails = 0;
  int instrCnt = 0, dataCnt = 0, rdCnt = 0, startCnt = 0, stopCnt = 0, sclViol = 0;
  logic [7:0] lastInstr = 8'h00, lastData = 8'h00;
  logic prevPull = 1'b0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign sdaBus = mSda & ~sdaPullLow;
  assign rdByte = rdBase + 8'(rdCnt) * 8'h35;

  twoWireSlave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaPullLow(sdaPullLow),
    .strapAddr(STRAP), .nvBusy(nvBusy), .engAck(engAck), .engRead(engRead),
    .rdByte(rdByte), .rxByte(rxByte), .instrValid(instrValid), .dataValid(dataValid),
    .rdNext(rdNext), .startSeen(startSeen), .stopSel(stopSel)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (instrValid) begin instrCnt++; lastInstr = rxByte; end
      if (dataValid)  begin dataCnt++;  lastData  = rxByte; end
      if (rdNext)     rdCnt++;
      if (startSeen)  startCnt++;
      if (stopSel)    stopCnt++;
      if (sdaPullLow != prevPull && mScl) sclViol++;
      prevPull = sdaPullLow;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit expAddrAck(logic [7:0] a, logic busy);
    return (a[7:4] == 4'b0101) && (a[3:0] == STRAP) && !busy;
  endfunction

  task automatic busStart();
    mScl = 1'b0; tick(6);
    mSda = 1'b1; tick(4);
    mScl = 1'b1; tick(8);
    mSda = 1'b0; tick(8);
    mScl = 1'b0;
  endtask

  task automatic busStop();
    tick(6); mSda = 1'b0; tick(4);
    mScl = 1'b1; tick(8);
    mSda = 1'b1; tick(8);
  endtask

  task automatic sendBit(bit b);
    tick(6); mSda = b; tick(4);
    mScl = 1'b1; tick(10);
    mScl = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    tick(6); mSda = 1'b1; tick(4);
    mScl = 1'b1; tick(5);
    ack = (sdaBus == 1'b0);
    tick(5); mScl = 1'b0;
  endtask

  task automatic recvByte(bit hostAck, output logic [7:0] v);
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick(6); mSda = 1'b1; tick(4);
      mScl = 1'b1; tick(5);
      v = {v[6:0], sdaBus};
      tick(5); mScl = 1'b0;
    end
    tick(6); mSda = ~hostAck; tick(4);
    mScl = 1'b1; tick(10);
    mScl = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit ack;
    logic [7:0] v, exp0;
    int c0, s0, i0, d0;
    void'($urandom(32'd20240611));
    tick(5);
    rstN = 1'b1;
    tick(5);
    chk(sdaPullLow == 1'b0 && stopCnt == 0, "R4", "reset silent", sdaPullLow, 0);

    // directed write transaction
    engAck = 1'b1; engRead = 1'b0;
    s0 = stopCnt;
    busStart();
    sendByte({4'b0101, STRAP}, ack);
    chk(ack, "R3", "address ack", ack, 1);
    sendByte(8'hC5, ack);
    chk(ack, "R6", "instruction ack", ack, 1);
    chk(lastInstr == 8'hC5, "R6", "instruction byte", lastInstr, 8'hC5);
    sendByte(8'h2B, ack);
    chk(ack, "R7", "data ack", ack, 1);
    chk(lastData == 8'h2B, "R7", "data byte", lastData, 8'h2B);
    busStop();
    chk(stopCnt == s0 + 1, "R2", "stop pulse after selected", stopCnt, s0 + 1);

    // wrong strap
    s0 = stopCnt; i0 = instrCnt;
    busStart();
    sendByte({4'b0101, STRAP ^ 4'h1}, ack);
    chk(!ack, "R4", "foreign strap nack", ack, 0);
    sendByte(8'h9A, ack);
    chk(!ack && instrCnt == i0, "R4", "no instr after foreign address", instrCnt, i0);
    busStop();
    chk(stopCnt == s0, "R2", "no stop pulse when unselected", stopCnt, s0);

    // wrong type nibble
    busStart();
    sendByte({4'b1101, STRAP}, ack);
    chk(!ack, "R3", "wrong type nack", ack, 0);
    busStop();

    // busy polling
    nvBusy = 1'b1;
    busStart();
    sendByte({4'b0101, STRAP}, ack);
    chk(!ack, "R5", "busy nack", ack, 0);
    busStop();
    nvBusy = 1'b0;
    busStart();
    sendByte({4'b0101, STRAP}, ack);
    chk(ack, "R5", "ack once idle", ack, 1);
    busStop();

    // engine refuses data
    busStart();
    sendByte({4'b0101, STRAP}, ack);
    sendByte(8'hC0, ack);
    engAck = 1'b0;
    d0 = dataCnt;
    sendByte(8'h11, ack);
    chk(!ack && dataCnt == d0 + 1, "R7", "refused data nack", ack, 0);
    engAck = 1'b1;
    sendByte(8'h22, ack);
    chk(!ack && dataCnt == d0 + 1, "R7", "later bytes ignored", dataCnt, d0 + 1);
    busStop();

    // read transaction
    rdBase = 8'hC3; engRead = 1'b1;
    busStart();
    sendByte({4'b0101, STRAP}, ack);
    sendByte(8'hB1, ack);
    chk(ack, "R6", "read instruction ack", ack, 1);
    c0 = rdCnt;
    exp0 = rdBase + 8'(c0) * 8'h35;
    recvByte(1'b1, v);
    chk(v == exp0, "R8", "first read byte", v, exp0);
    chk(rdCnt == c0 + 1, "R8", "rdNext on host ack", rdCnt, c0 + 1);
    exp0 = rdBase + 8'(c0 + 1) * 8'h35;
    recvByte(1'b0, v);
    chk(v == exp0, "R8", "second read byte", v, exp0);
    recvByte(1'b0, v);
    chk(v == 8'hFF && rdCnt == c0 + 1, "R8", "silent after host nack", v, 8'hFF);
    busStop();
    engRead = 1'b0;

    // START in the middle of a byte
    i0 = startCnt;
    busStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStart();
    chk(startCnt == i0 + 2, "R1", "start pulses", startCnt, i0 + 2);
    sendByte({4'b0101, STRAP}, ack);
    chk(ack, "R1", "address ack after restart", ack, 1);
    sendByte(8'h5D, ack);
    chk(lastInstr == 8'h5D, "R1", "instr after restart", lastInstr, 8'h5D);
    busStop();

    // constrained random write traffic
    for (int k = 0; k < 24; k++) begin
      logic [7:0] addr, ins, dat;
      logic busy;
      bit expAck;
      addr = ($urandom % 4 != 0) ? {4'b0101, STRAP} : 8'($urandom);
      busy = ($urandom % 5 == 0);
      ins  = 8'($urandom);
      dat  = 8'($urandom);
      expAck = expAddrAck(addr, busy);
      nvBusy = busy;
      s0 = stopCnt;
      busStart();
      sendByte(addr, ack);
      chk(ack == expAck, busy ? "R5" : "R3", "random address ack", ack, expAck);
      if (expAck) begin
        sendByte(ins, ack);
        chk(ack && lastInstr == ins, "R6", "random instr", lastInstr, ins);
        sendByte(dat, ack);
        chk(ack && lastData == dat, "R7", "random data", lastData, dat);
      end
      busStop();
      chk(stopCnt == s0 + int'(expAck), "R2", "random stop pulse", stopCnt, s0 + int'(expAck));
      nvBusy = 1'b0;
    end

    chk(sclViol == 0, "R9", "pull changed while SCL high", sclViol, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule